// File: doc/BRIEF.md
# EEPROM Page Buffer and Self-Timed Programmer

This block sits between the serial slave front-end of a small EEPROM and its nonvolatile array. While a write transaction is in progress, the front-end loads the starting address pointer. It then pushes each received data byte into a small page buffer. When the bus transaction ends, the front-end raises a start request. The block then copies the buffered bytes into the array, one byte per program time unit, in the order they were received.

While the block is programming, it holds a busy flag high. The front-end uses that flag to withhold acknowledge. The buffer depth is a parameter: 2 entries for the small array and 8 entries for the large one.

- In the 8-entry configuration, extra bytes wrap and overwrite the earliest buffer entries.
- In the 2-entry configuration, extra bytes are dropped.

Successive bytes go to successive array addresses. Only the page-local low bits of the address advance, so the upper bits stay fixed and programming never leaves the aligned page. The length of a program time unit is a parameter given in clock cycles.

Top module: `eeprom_page_prog`

## Requirements
- R1: After a synchronous reset, `busy` and `arr_we` are 0 and the buffer is empty.
- R2: A pulse on `ptr_load` (while idle) stores `ptr_in` as the start address and empties the buffer. Each accepted `byte_wr` stores `byte_in` in the next buffer entry. Programming writes entry k to address start+k, in entry order 0, 1, 2, and so on.
- R3: The address offset k is added only to the low log2(DEPTH) bits of the start address (3 bits for DEPTH=8), modulo DEPTH. The upper address bits are those of the start address for every strobe.
- R4: With DEPTH=8, byte number i (counting from 0) lands in entry i mod 8, so the latest byte wins. The stored count saturates at 8, and all 8 entries are programmed.
- R5: With DEPTH=2, bytes after the second are dropped. The first two bytes are programmed at start and start with bit 0 toggled.
- R6: A cycle with `prog_go` high while idle and the buffer non-empty starts programming: `busy` is high at the next clock edge. `prog_go` with an empty buffer has no effect.
- R7: Each entry produces exactly one one-cycle `arr_we` pulse, with `arr_addr` and `arr_data` valid in the same cycle. Strobes are UNIT_CYCLES clocks apart. The first strobe comes in the first busy cycle. `busy` stays high for exactly N×UNIT_CYCLES cycles, where N is the number of entries programmed.
- R8: While `busy` is high, `byte_wr`, `ptr_load`, `abort` and `prog_go` are ignored. The buffer count and the start address are unchanged.
- R9: `abort` while idle empties the buffer without programming. When inputs coincide, the priority is: `abort` first, then `ptr_load`, then `prog_go`, then `byte_wr`.
- R10: When programming completes, the buffer is empty, so a new `prog_go` without new bytes does nothing. The start address is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_load | input | 1 | Load start address and empty buffer |
| ptr_in | input | ADDR_W | Start address value |
| byte_wr | input | 1 | Push one received byte |
| byte_in | input | DATA_W | Received byte |
| prog_go | input | 1 | Start request issued at bus STOP |
| abort | input | 1 | Discard the buffered transaction |
| busy | output | 1 | Programming in progress |
| arr_we | output | 1 | Array write strobe, one cycle per byte |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |

## Verification
The hardest case to reach is overflow in the 8-entry buffer. Pushing more than eight bytes makes some entries hold later bytes while their address offsets stay tied to the entry position. Start addresses that sit near the top of a page make the low bits wrap at the same time. The stimulus table therefore mixes byte counts of 11 and 16 with start offsets of 3, 6 and 7, and the bench works out which byte survives in each entry.

The second hard case is that control inputs arriving mid-program must be ignored. A directed test pulses each of them during `busy`, then checks that the strobe count stays the same and that a later transaction without a pointer load still uses the original address. A 2-entry instance receives the same stimulus, which exposes the drop-on-overflow variant.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic {
    PG_IDLE = 1'b0,
    PG_RUN  = 1'b1
  } pg_state_e;
endpackage

// File: rtl/pb_fill.sv
// Write index and saturating fill counter for the page buffer.
module pb_fill #(
  parameter int DEPTH = 8,
  parameter bit WRAP  = 1'b1,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  output logic             accept,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] cnt
);
  logic full;
  assign full = (cnt == CNT_W'(DEPTH));

  generate
    if (WRAP) begin : g_wrap
      // overflow rolls the index over and overwrites the oldest entry
      assign accept = push;
    end else begin : g_drop
      assign accept = push && !full;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_idx <= '0;
      cnt    <= '0;
    end else if (accept) begin
      wr_idx <= wr_idx + 1'b1;
      if (!full) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pb_ram.sv
// Page storage, one write port and one registered read port.
module pb_ram #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pb_seq.sv
// Self-timed sequencer: one array strobe per entry, UNIT_CYCLES apart.
module pb_seq
  import pb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 3,
  parameter int CNT_W       = 4,
  parameter int UNIT_CYCLES = 4,
  parameter int TMR_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] base,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              done
);
  pg_state_e        st;
  logic [CNT_W-1:0] slot;
  logic [TMR_W-1:0] tmr;
  logic             start, run, last_tick, last_slot, adv;

  always_comb begin
    run       = (st == PG_RUN);
    start     = (st == PG_IDLE) && go && (cnt != '0);
    last_tick = (tmr == TMR_W'(UNIT_CYCLES - 1));
    last_slot = (slot == cnt - 1'b1);
    adv       = run && last_tick && !last_slot;
    done      = run && last_tick && last_slot;
    rd_en     = start || adv;
    rd_idx    = start ? '0 : IDX_W'(slot + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PG_IDLE;
      busy     <= 1'b0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
      slot     <= '0;
      tmr      <= '0;
    end else begin
      arr_we <= rd_en;
      if (rd_en)
        arr_addr <= {base[ADDR_W-1:IDX_W], base[IDX_W-1:0] + rd_idx};
      if (start) begin
        st   <= PG_RUN;
        busy <= 1'b1;
        slot <= '0;
        tmr  <= '0;
      end else if (run) begin
        if (last_tick) begin
          tmr <= '0;
          if (last_slot) begin
            st   <= PG_IDLE;
            busy <= 1'b0;
          end else begin
            slot <= slot + 1'b1;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog #(
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int UNIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic              byte_wr,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              prog_go,
  input  logic              abort,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TMR_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam bit WRAP  = (DEPTH > 2);

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  fill_cnt;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              push, accept, clear, done, rd_en, go;

  // priority: abort > ptr_load > prog_go > byte_wr; all gated while busy
  assign go    = prog_go && !abort && !ptr_load;
  assign push  = byte_wr && !busy && !abort && !ptr_load && !prog_go;
  assign clear = done || (!busy && (abort || ptr_load));

  always_ff @(posedge clk) begin
    if (rst)                    base_q <= '0;
    else if (ptr_load && !busy && !abort) base_q <= ptr_in;
  end

  pb_fill #(.DEPTH(DEPTH), .WRAP(WRAP), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst(rst), .clear(clear), .push(push),
    .accept(accept), .wr_idx(wr_idx), .cnt(fill_cnt)
  );

  pb_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(accept), .waddr(wr_idx), .wdata(byte_in),
    .re(rd_en), .raddr(rd_idx), .rdata(arr_data)
  );

  pb_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
           .UNIT_CYCLES(UNIT_CYCLES), .TMR_W(TMR_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .cnt(fill_cnt), .base(base_q),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .rd_en(rd_en), .rd_idx(rd_idx), .done(done)
  );
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 3,
  parameter int CNT_W       = 4,
  parameter int UNIT_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_go,
  input logic              abort,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [CNT_W-1:0]  fill_cnt
);
  p_reset_r1: assert property (@(posedge clk) $past(rst) |-> !busy && !arr_we);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(DEPTH));

  p_start_on_go_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(prog_go) && ($past(fill_cnt) != '0));

  p_page_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(arr_addr[ADDR_W-1:IDX_W]));

  p_we_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(fill_cnt));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (rst)
    abort && !busy |=> fill_cnt == '0);

  generate
    if (UNIT_CYCLES > 1) begin : g_pulse
      p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> !arr_we);
    end
  endgenerate
endmodule

bind eeprom_page_prog pb_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
  .UNIT_CYCLES(UNIT_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .prog_go(prog_go), .abort(abort), .busy(busy),
  .arr_we(arr_we), .arr_addr(arr_addr), .fill_cnt(fill_cnt)
);

// File: tb/eeprom_page_prog_test.sv
module eeprom_page_prog_test;
  localparam int U = 4;

  logic       clk = 0, rst = 1;
  logic       ptr_load = 0, byte_wr = 0, prog_go = 0, abort = 0;
  logic [7:0] ptr_in = 0, byte_in = 0;
  logic       busy, arr_we, busy_s, arr_we_s;
  logic [7:0] arr_addr, arr_data, arr_addr_s, arr_data_s;

  int checks = 0, errors = 0;
  int ns = 0, bcnt = 0, ncyc = 0, ns_s = 0, bcnt_s = 0;
  int sa [128], sd [128], sc [128], sa_s [32], sd_s [32];

  always #2.5 clk = ~clk;

  eeprom_page_prog #(.DEPTH(8), .UNIT_CYCLES(U)) uut (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_in(ptr_in),
    .byte_wr(byte_wr), .byte_in(byte_in), .prog_go(prog_go), .abort(abort),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data));

  eeprom_page_prog #(.DEPTH(2), .UNIT_CYCLES(U)) uut_s (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_in(ptr_in),
    .byte_wr(byte_wr), .byte_in(byte_in), .prog_go(prog_go), .abort(abort),
    .busy(busy_s), .arr_we(arr_we_s), .arr_addr(arr_addr_s), .arr_data(arr_data_s));

  always @(negedge clk) begin
    if (busy) bcnt++;
    if (arr_we && ns < 128) begin
      sa[ns] = arr_addr; sd[ns] = arr_data; sc[ns] = ncyc; ns++;
    end
    if (busy_s) bcnt_s++;
    if (arr_we_s && ns_s < 32) begin
      sa_s[ns_s] = arr_addr_s; sd_s[ns_s] = arr_data_s; ns_s++;
    end
    ncyc++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_ptr(input logic [7:0] a);
    ptr_load = 1; ptr_in = a; @(negedge clk); ptr_load = 0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    byte_wr = 1; byte_in = d; @(negedge clk); byte_wr = 0;
  endtask
  task automatic pulse_go();
    prog_go = 1; @(negedge clk); prog_go = 0;
  endtask
  task automatic pulse_abort();
    abort = 1; @(negedge clk); abort = 0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  // {start address, byte count, first data value}
  localparam logic [23:0] VEC [6] = '{
    {8'h10, 8'd1,  8'hA0},
    {8'h3E, 8'd4,  8'h11},
    {8'h00, 8'd8,  8'h20},
    {8'h5B, 8'd11, 8'h40},
    {8'hFF, 8'd2,  8'h7E},
    {8'h77, 8'd16, 8'h90}
  };

  initial begin
    int ns0, b0, bs0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 arr_we", arr_we, 0);
    chk("R1 no strobes", ns, 0);

    // R6: start with empty buffer does nothing
    pulse_go();
    repeat (2) @(negedge clk);
    chk("R6 empty go busy", busy, 0);
    chk("R6 empty go strobes", ns, 0);

    // table walk: R2 R3 R4 R7
    for (int v = 0; v < 6; v++) begin
      logic [7:0] a, n, sd0;
      int nn;
      {a, n, sd0} = VEC[v];
      nn = (n > 8) ? 8 : int'(n);
      pulse_ptr(a);
      for (int i = 0; i < n; i++) pulse_byte(8'(sd0 + i));
      ns0 = ns; b0 = bcnt;
      pulse_go();
      chk("R6 busy after go", busy, 1);
      wait_idle();
      chk("R7 strobe count", ns - ns0, nn);
      chk("R7 busy length", bcnt - b0, nn * U);
      for (int k = 0; k < nn; k++) begin
        logic [7:0] ea, ed;
        ea = {a[7:3], 3'(a[2:0] + 3'(k))};
        ed = 8'(int'(sd0) + k + 8 * ((int'(n) - 1 - k) / 8));
        chk("R3 page address", sa[ns0 + k], ea);
        chk("R4 entry data", sd[ns0 + k], ed);
        chk("R7 strobe spacing", sc[ns0 + k] - sc[ns0], k * U);
      end
    end

    // R8: control inputs during busy are ignored
    pulse_ptr(8'h20);
    pulse_byte(8'h55);
    pulse_byte(8'h66);
    ns0 = ns; b0 = bcnt;
    pulse_go();
    pulse_byte(8'hEE);
    pulse_ptr(8'h90);
    pulse_abort();
    pulse_go();
    wait_idle();
    chk("R8 strobe count", ns - ns0, 2);
    chk("R8 busy length", bcnt - b0, 2 * U);
    chk("R8 addr0", sa[ns0], 8'h20);
    chk("R8 addr1", sa[ns0 + 1], 8'h21);
    chk("R8 data0", sd[ns0], 8'h55);
    chk("R8 data1", sd[ns0 + 1], 8'h66);

    // R10: buffer empty after completion
    ns0 = ns;
    pulse_go();
    repeat (2) @(negedge clk);
    chk("R10 go after done busy", busy, 0);
    chk("R10 go after done strobes", ns - ns0, 0);

    // R8/R10: start address kept, ignored ptr_load did not change it
    pulse_byte(8'h77);
    ns0 = ns;
    pulse_go();
    wait_idle();
    chk("R8 kept address strobes", ns - ns0, 1);
    chk("R8 kept address", sa[ns0], 8'h20);
    chk("R2 single data", sd[ns0], 8'h77);

    // R9: abort empties buffer without programming
    pulse_ptr(8'h30);
    pulse_byte(8'h01);
    pulse_byte(8'h02);
    pulse_byte(8'h03);
    pulse_abort();
    ns0 = ns;
    pulse_go();
    repeat (2) @(negedge clk);
    chk("R9 abort busy", busy, 0);
    chk("R9 abort strobes", ns - ns0, 0);
    pulse_byte(8'h99);
    pulse_go();
    wait_idle();
    chk("R9 after abort strobes", ns - ns0, 1);
    chk("R9 after abort addr", sa[ns0], 8'h30);
    chk("R9 after abort data", sd[ns0], 8'h99);

    // R5: two-entry variant drops extra bytes, low bit toggles
    pulse_ptr(8'h41);
    pulse_byte(8'h01);
    pulse_byte(8'h02);
    pulse_byte(8'h03);
    ns0 = ns_s; bs0 = bcnt_s;
    pulse_go();
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R5 small strobes", ns_s - ns0, 2);
    chk("R5 small busy", bcnt_s - bs0, 2 * U);
    chk("R5 small addr0", sa_s[ns0], 8'h41);
    chk("R5 small addr1", sa_s[ns0 + 1], 8'h40);
    chk("R5 small data0", sd_s[ns0], 8'h01);
    chk("R5 small data1", sd_s[ns0 + 1], 8'h02);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule